// File: doc/BRIEF.md
# Best-Fit Range Allocator

This block keeps track of a linear address area of a fixed size. It stores the area as a small table of ranges. Each range has a start offset, a nonzero length and a used/free flag. The ranges are kept in address order, and each one begins exactly where the one before it ends. The caller can make three kinds of request:

- **Allocate** carves a span of the requested length out of the tightest-fitting free range.
- **Free** returns a span, identified by its exact start offset.
- **Clear** puts the table back to one free range that covers the whole area.

Every table walk runs one entry per clock under a small controller. These walks are the best-fit search, the upward shift that opens a slot for a split, and the downward shift that closes gaps after a merge. A request enters on a valid/ready handshake, and the result leaves on a second valid/ready handshake.

Back-pressure works as follows:

- `req_ready` is high only while the controller is idle.
- Exactly one request is in flight at a time.
- The response (`rsp_offset`, `rsp_status`) appears with `rsp_valid`. It stays unchanged until the cycle in which `rsp_ready` is high.
- No new request is taken before that response has been consumed.
- `busy` is high from the cycle after a request is accepted until its response has been taken.

Top module: `range_alloc`

## Requirements
- R1: After `rst_n` is deasserted, and after a Clear request, the table holds one free range at offset 0 spanning the whole area. A Clear request answers with status OK and offset 0.
- R2: Allocate chooses the free range of smallest length that is at least the requested length. When several such ranges have the same length, the one at the lowest address is chosen.
- R3: If the chosen range is longer than requested, the allocated span is taken from its top end. The response offset is then range offset + range length − requested length, and the remainder stays free at the range's offset. An exact fit returns the range's own offset.
- R4: If no free range is long enough, Allocate answers NOMEM with an all-ones offset. A requested length of 0 answers INVAL with an all-ones offset. Neither case changes the table.
- R5: If the table already holds DEPTH ranges, an Allocate that would need a split answers NOMEM with an all-ones offset and leaves the table unchanged. An exact fit still succeeds in that state.
- R6: A Free whose offset matches no range start, or matches a range that is already free, answers INVAL and changes nothing. A successful Free answers OK. Every Free response echoes the given offset.
- R7: A freed range merges with its free neighbours, whether only the lower one, only the upper one, or both are free. As a result, a later Allocate can take the whole merged span.
- R8: `req_ready` is high only when idle. `busy` rises after an accepted request and stays high until its response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady.
- R9: `req_op` encoding is 0 = Clear, 1 = Allocate (`req_arg` = length), 2 = Free (`req_arg` = offset), 3 = reserved. A reserved request answers INVAL with an all-ones offset and changes nothing. `rsp_status` encoding is 0 = OK, 1 = NOMEM, 2 = INVAL.
- R10: Whenever the controller is idle or presenting a response, the table satisfies three conditions:
  - every range below the count has a nonzero length;
  - each such range starts at the end of the one before it;
  - the last range ends at the area size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_op | input | 2 | Operation code (R9) |
| req_arg | input | AW | Length for Allocate, offset for Free |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_offset | output | AW | Allocated or echoed offset; all ones on failure |
| rsp_status | output | 2 | Result code (R9) |
| busy | output | 1 | A request is in progress |

## Verification
The bench builds the block with DEPTH = 6, AW = 12 and an area of 1024. With so few entries, five small allocations fill the table, so the full-table split refusal and the exact-fit-while-full path both come within reach in a few requests. Directed scenarios cover the following cases, each with expected offsets worked out by hand:

- tie-breaking;
- top-end splits;
- each of the three merge shapes.

A long sequence of mixed requests is then compared result by result against a behavioural model of the same policy. That model checks its own contiguity after every step.

// File: rtl/range_alloc_pkg.sv
package range_alloc_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_ALLOC = 2'd1,
    OP_FREE  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NOMEM = 2'd1,
    ST_INVAL = 2'd2
  } status_e;

  typedef enum logic [2:0] {
    FS_IDLE   = 3'd0,
    FS_SCAN   = 3'd1,
    FS_GROW   = 3'd2,
    FS_MERGE  = 3'd3,
    FS_SHRINK = 3'd4,
    FS_RESP   = 3'd5
  } fsm_e;

endpackage

// File: rtl/range_alloc_table.sv
module range_alloc_table #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int AREA  = 4096,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          quiet,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  logic [AW-1:0] wa_off,
  input  logic [AW-1:0] wa_size,
  input  logic          wa_used,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [AW-1:0] wb_off,
  input  logic [AW-1:0] wb_size,
  input  logic          wb_used,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_d,
  output logic [AW-1:0] off_q  [DEPTH],
  output logic [AW-1:0] size_q [DEPTH],
  output logic          used_q [DEPTH],
  output logic [CW-1:0] cnt_q
);

  localparam logic [AW-1:0] AREA_V = AW'(AREA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        off_q[i]  <= '0;
        size_q[i] <= (i == 0) ? AREA_V : '0;
        used_q[i] <= 1'b0;
      end
      cnt_q <= CW'(1);
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        off_q[i]  <= '0;
        size_q[i] <= (i == 0) ? AREA_V : '0;
        used_q[i] <= 1'b0;
      end
      cnt_q <= CW'(1);
    end else begin
      if (wa_en) begin
        off_q[wa_idx]  <= wa_off;
        size_q[wa_idx] <= wa_size;
        used_q[wa_idx] <= wa_used;
      end
      if (wb_en) begin
        off_q[wb_idx]  <= wb_off;
        size_q[wb_idx] <= wb_size;
        used_q[wb_idx] <= wb_used;
      end
      if (cnt_we) cnt_q <= cnt_d;
    end
  end

  // Table shape checks, valid whenever no walk is in progress
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CW'(DEPTH)))
    else $error("entry count out of range");

  for (genvar i = 0; i < DEPTH; i++) begin : g_shape
    p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && (CW'(i) < cnt_q)) |-> (size_q[i] != '0))
      else $error("zero-length live range at %0d", i);

    p_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && (CW'(i + 1) == cnt_q)) |->
      (({1'b0, off_q[i]} + {1'b0, size_q[i]}) == (AW + 1)'(AREA)))
      else $error("last range does not reach area end");

    if (i + 1 < DEPTH) begin : g_pair
      p_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (CW'(i + 1) < cnt_q)) |->
        (off_q[i+1] == off_q[i] + size_q[i]))
        else $error("gap or overlap after range %0d", i);
    end
  end

endmodule

// File: rtl/range_alloc_scan.sv
module range_alloc_scan #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          match,
  input  logic [AW-1:0] key,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] cur_off,
  input  logic [AW-1:0] cur_size,
  input  logic          cur_used,
  output logic [IW-1:0] idx,
  output logic          done,
  output logic          found,
  output logic [IW-1:0] hit
);

  logic          run_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] hit_q;
  logic [AW-1:0] best_q;
  logic          found_q;
  logic          done_q;
  logic          take;
  logic          last;

  // Exact-offset lookup for Free, strict-smaller best fit for Allocate
  always_comb begin
    if (match) take = (cur_off == key);
    else       take = !cur_used && (cur_size >= key) &&
                      (!found_q || (cur_size < best_q));
  end

  assign last = ((CW'(idx_q) + CW'(1)) >= cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
      hit_q   <= '0;
      best_q  <= '0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        idx_q   <= '0;
        hit_q   <= '0;
        best_q  <= '0;
        found_q <= 1'b0;
      end else if (run_q) begin
        if (take) begin
          found_q <= 1'b1;
          hit_q   <= idx_q;
          best_q  <= cur_size;
        end
        if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign idx   = idx_q;
  assign done  = done_q;
  assign found = found_q;
  assign hit   = hit_q;

  p_hit_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && found_q) |-> (CW'(hit_q) < cnt))
    else $error("scan hit beyond live entries");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("scan done held for more than one cycle");

endmodule

// File: rtl/range_alloc.sv
module range_alloc
  import range_alloc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int AREA  = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_arg,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_offset,
  output logic [1:0]    rsp_status,
  output logic          busy
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] BAD  = '1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  fsm_e          state_q, state_d;
  op_e           op_q, op_d;
  logic [AW-1:0] arg_q, arg_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] tgt_q, tgt_d;
  logic [1:0]    deln_q, deln_d;
  logic [AW-1:0] roff_q, roff_d;
  status_e       rst_q, rst_d;

  logic          clear, quiet;
  logic          wa_en, wa_used, wb_en, wb_used, cnt_we;
  logic [IW-1:0] wa_idx, wb_idx;
  logic [AW-1:0] wa_off, wa_size, wb_off, wb_size;
  logic [CW-1:0] cnt_d;
  logic [AW-1:0] t_off  [DEPTH];
  logic [AW-1:0] t_size [DEPTH];
  logic          t_used [DEPTH];
  logic [CW-1:0] t_cnt;

  logic          sc_start, sc_done, sc_found;
  logic [IW-1:0] sc_idx, sc_hit;

  logic [CW-1:0] tgt_c, src_c;
  logic [IW-1:0] tgt_m1, tgt_p1;
  logic          lo_free, hi_free;
  logic [AW-1:0] lo_len, split_off;

  range_alloc_table #(.AW(AW), .DEPTH(DEPTH), .AREA(AREA)) u_table (
    .clk(clk), .rst_n(rst_n), .clear(clear), .quiet(quiet),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_off(wa_off), .wa_size(wa_size), .wa_used(wa_used),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_off(wb_off), .wb_size(wb_size), .wb_used(wb_used),
    .cnt_we(cnt_we), .cnt_d(cnt_d),
    .off_q(t_off), .size_q(t_size), .used_q(t_used), .cnt_q(t_cnt)
  );

  range_alloc_scan #(.AW(AW), .DEPTH(DEPTH)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(sc_start), .match(op_q == OP_FREE),
    .key(arg_q), .cnt(t_cnt),
    .cur_off(t_off[sc_idx]), .cur_size(t_size[sc_idx]), .cur_used(t_used[sc_idx]),
    .idx(sc_idx), .done(sc_done), .found(sc_found), .hit(sc_hit)
  );

  assign tgt_c     = CW'(tgt_q);
  assign tgt_m1    = tgt_q - IW'(1);
  assign tgt_p1    = tgt_q + IW'(1);
  assign src_c     = ptr_q + CW'(deln_q);
  assign lo_free   = (tgt_q != '0) && !t_used[tgt_m1];
  assign hi_free   = ((tgt_c + CW'(1)) < t_cnt) && !t_used[tgt_p1];
  assign lo_len    = t_size[tgt_q] - arg_q;
  assign split_off = t_off[tgt_q] + lo_len;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    arg_d    = arg_q;
    ptr_d    = ptr_q;
    tgt_d    = tgt_q;
    deln_d   = deln_q;
    roff_d   = roff_q;
    rst_d    = rst_q;
    clear    = 1'b0;
    sc_start = 1'b0;
    wa_en    = 1'b0;
    wa_idx   = '0;
    wa_off   = '0;
    wa_size  = '0;
    wa_used  = 1'b0;
    wb_en    = 1'b0;
    wb_idx   = '0;
    wb_off   = '0;
    wb_size  = '0;
    wb_used  = 1'b0;
    cnt_we   = 1'b0;
    cnt_d    = t_cnt;
    unique case (state_q)
      FS_IDLE: begin
        if (req_valid) begin
          op_d  = op_e'(req_op);
          arg_d = req_arg;
          unique case (op_e'(req_op))
            OP_CLEAR: begin
              clear   = 1'b1;
              roff_d  = '0;
              rst_d   = ST_OK;
              state_d = FS_RESP;
            end
            OP_ALLOC: begin
              if (req_arg == '0) begin
                roff_d  = BAD;
                rst_d   = ST_INVAL;
                state_d = FS_RESP;
              end else begin
                sc_start = 1'b1;
                state_d  = FS_SCAN;
              end
            end
            OP_FREE: begin
              sc_start = 1'b1;
              state_d  = FS_SCAN;
            end
            default: begin
              roff_d  = BAD;
              rst_d   = ST_INVAL;
              state_d = FS_RESP;
            end
          endcase
        end
      end
      FS_SCAN: begin
        if (sc_done) begin
          if (op_q == OP_ALLOC) begin
            if (!sc_found) begin
              roff_d  = BAD;
              rst_d   = ST_NOMEM;
              state_d = FS_RESP;
            end else if (t_size[sc_hit] == arg_q) begin
              wa_en   = 1'b1;
              wa_idx  = sc_hit;
              wa_off  = t_off[sc_hit];
              wa_size = arg_q;
              wa_used = 1'b1;
              roff_d  = t_off[sc_hit];
              rst_d   = ST_OK;
              state_d = FS_RESP;
            end else if (t_cnt == FULL) begin
              roff_d  = BAD;
              rst_d   = ST_NOMEM;
              state_d = FS_RESP;
            end else begin
              tgt_d   = sc_hit;
              ptr_d   = t_cnt;
              state_d = FS_GROW;
            end
          end else begin
            roff_d = arg_q;
            if (!sc_found || !t_used[sc_hit]) begin
              rst_d   = ST_INVAL;
              state_d = FS_RESP;
            end else begin
              tgt_d   = sc_hit;
              state_d = FS_MERGE;
            end
          end
        end
      end
      FS_GROW: begin
        if (ptr_q > tgt_c + CW'(1)) begin
          // open a slot: move entry ptr-1 up to ptr
          wa_en   = 1'b1;
          wa_idx  = ptr_q[IW-1:0];
          wa_off  = t_off[IW'(ptr_q - CW'(1))];
          wa_size = t_size[IW'(ptr_q - CW'(1))];
          wa_used = t_used[IW'(ptr_q - CW'(1))];
          ptr_d   = ptr_q - CW'(1);
        end else begin
          wa_en   = 1'b1;
          wa_idx  = tgt_q;
          wa_off  = t_off[tgt_q];
          wa_size = lo_len;
          wa_used = 1'b0;
          wb_en   = 1'b1;
          wb_idx  = tgt_p1;
          wb_off  = split_off;
          wb_size = arg_q;
          wb_used = 1'b1;
          cnt_we  = 1'b1;
          cnt_d   = t_cnt + CW'(1);
          roff_d  = split_off;
          rst_d   = ST_OK;
          state_d = FS_RESP;
        end
      end
      FS_MERGE: begin
        rst_d = ST_OK;
        if (lo_free) begin
          wa_en   = 1'b1;
          wa_idx  = tgt_m1;
          wa_off  = t_off[tgt_m1];
          wa_size = t_size[tgt_m1] + t_size[tgt_q] + (hi_free ? t_size[tgt_p1] : '0);
          wa_used = 1'b0;
          ptr_d   = tgt_c;
          deln_d  = hi_free ? 2'd2 : 2'd1;
          state_d = FS_SHRINK;
        end else if (hi_free) begin
          wa_en   = 1'b1;
          wa_idx  = tgt_q;
          wa_off  = t_off[tgt_q];
          wa_size = t_size[tgt_q] + t_size[tgt_p1];
          wa_used = 1'b0;
          ptr_d   = tgt_c + CW'(1);
          deln_d  = 2'd1;
          state_d = FS_SHRINK;
        end else begin
          wa_en   = 1'b1;
          wa_idx  = tgt_q;
          wa_off  = t_off[tgt_q];
          wa_size = t_size[tgt_q];
          wa_used = 1'b0;
          state_d = FS_RESP;
        end
      end
      FS_SHRINK: begin
        if (src_c < t_cnt) begin
          wa_en   = 1'b1;
          wa_idx  = ptr_q[IW-1:0];
          wa_off  = t_off[src_c[IW-1:0]];
          wa_size = t_size[src_c[IW-1:0]];
          wa_used = t_used[src_c[IW-1:0]];
          ptr_d   = ptr_q + CW'(1);
        end else begin
          cnt_we  = 1'b1;
          cnt_d   = t_cnt - CW'(deln_q);
          state_d = FS_RESP;
        end
      end
      FS_RESP: begin
        if (rsp_ready) state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      op_q    <= OP_CLEAR;
      arg_q   <= '0;
      ptr_q   <= '0;
      tgt_q   <= '0;
      deln_q  <= '0;
      roff_q  <= '0;
      rst_q   <= ST_OK;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      arg_q   <= arg_d;
      ptr_q   <= ptr_d;
      tgt_q   <= tgt_d;
      deln_q  <= deln_d;
      roff_q  <= roff_d;
      rst_q   <= rst_d;
    end
  end

  assign quiet      = (state_q == FS_IDLE) || (state_q == FS_RESP);
  assign req_ready  = (state_q == FS_IDLE);
  assign busy       = (state_q != FS_IDLE);
  assign rsp_valid  = (state_q == FS_RESP);
  assign rsp_offset = roff_q;
  assign rsp_status = rst_q;

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy)
    else $error("accepted request did not raise busy");

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_offset) && $stable(rsp_status)))
    else $error("response changed under back-pressure");

  p_fail_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == ST_NOMEM)) |-> (rsp_offset == BAD))
    else $error("NOMEM response without all-ones offset");

  p_grow_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_GROW) |-> (t_cnt < FULL))
    else $error("split started on a full table");

  p_alloc_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (op_q == OP_ALLOC) && (rsp_status == ST_OK)) |->
    ({1'b0, rsp_offset} + {1'b0, arg_q} <= (AW + 1)'(AREA)))
    else $error("allocated span leaves the area");

endmodule

// File: tb/range_alloc_tb_top.sv
module range_alloc_tb_top;

  localparam int AW         = 12;
  localparam int DEPTH      = 6;
  localparam int AREA       = 1024;
  localparam int CLK_PERIOD = 10;
  localparam int BAD        = (1 << AW) - 1;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_arg = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_offset;
  logic [1:0]    rsp_status;
  logic          busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural reference table
  int m_cnt;
  int m_off  [DEPTH];
  int m_size [DEPTH];
  bit m_used [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  range_alloc #(.AW(AW), .DEPTH(DEPTH), .AREA(AREA)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_offset(rsp_offset),
    .rsp_status(rsp_status), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = 1;
    m_off[0] = 0;
    m_size[0] = AREA;
    m_used[0] = 1'b0;
  endtask

  task automatic m_remove(input int k);
    for (int j = k; j < m_cnt - 1; j++) begin
      m_off[j] = m_off[j+1];
      m_size[j] = m_size[j+1];
      m_used[j] = m_used[j+1];
    end
    m_cnt--;
  endtask

  task automatic m_alloc(input int sz, output int off, output int st);
    int best;
    best = -1;
    if (sz == 0) begin
      off = BAD; st = 2; return;
    end
    for (int i = 0; i < m_cnt; i++)
      if (!m_used[i] && m_size[i] >= sz && (best < 0 || m_size[i] < m_size[best])) best = i;
    if (best < 0) begin
      off = BAD; st = 1;
    end else if (m_size[best] == sz) begin
      m_used[best] = 1'b1; off = m_off[best]; st = 0;
    end else if (m_cnt == DEPTH) begin
      off = BAD; st = 1;
    end else begin
      for (int j = m_cnt; j > best + 1; j--) begin
        m_off[j] = m_off[j-1]; m_size[j] = m_size[j-1]; m_used[j] = m_used[j-1];
      end
      m_size[best] = m_size[best] - sz;
      m_off[best+1] = m_off[best] + m_size[best];
      m_size[best+1] = sz;
      m_used[best+1] = 1'b1;
      m_cnt++;
      off = m_off[best+1]; st = 0;
    end
  endtask

  task automatic m_free(input int o, output int st);
    int hit;
    hit = -1;
    for (int i = 0; i < m_cnt; i++) if (m_off[i] == o) hit = i;
    if (hit < 0 || !m_used[hit]) begin
      st = 2; return;
    end
    m_used[hit] = 1'b0;
    if (hit + 1 < m_cnt && !m_used[hit+1]) begin
      m_size[hit] += m_size[hit+1];
      m_remove(hit + 1);
    end
    if (hit > 0 && !m_used[hit-1]) begin
      m_size[hit-1] += m_size[hit];
      m_remove(hit);
    end
    st = 0;
  endtask

  // R10: the reference keeps its own ranges contiguous and covering
  task automatic m_shape();
    int pos;
    bit ok;
    pos = 0;
    ok = 1'b1;
    for (int i = 0; i < m_cnt; i++) begin
      if (m_off[i] != pos || m_size[i] == 0) ok = 1'b0;
      pos = m_off[i] + m_size[i];
    end
    chk("R10 model contiguity", int'(ok && pos == AREA), 1);
  endtask

  task automatic do_op(input int op, input int arg, output int off, output int st);
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op[1:0];
    req_arg = arg[AW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    off = int'(rsp_offset);
    st = int'(rsp_status);
  endtask

  // run one request on both design and model, compare everything
  task automatic op_cmp(input string tag, input int op, input int arg, output int off);
    int st, e_off, e_st;
    do_op(op, arg, off, st);
    case (op)
      0: begin m_reset(); e_off = 0; e_st = 0; end
      1: m_alloc(arg, e_off, e_st);
      2: begin m_free(arg, e_st); e_off = arg; end
      default: begin e_off = BAD; e_st = 2; end
    endcase
    chk({tag, " status"}, st, e_st);
    chk({tag, " offset"}, off, e_off);
    m_shape();
  endtask

  task automatic t_reset_state();
    int o;
    chk("R8 idle ready after reset", int'(req_ready), 1);
    chk("R8 no busy after reset", int'(busy), 0);
    chk("R8 no response after reset", int'(rsp_valid), 0);
    m_reset();
    op_cmp("R1 full-area alloc after reset", 1, AREA, o);
    chk("R1 whole area at offset 0", o, 0);
    op_cmp("R1 release whole area", 2, 0, o);
  endtask

  task automatic t_best_fit();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    op_cmp("R3 top split a", 1, 100, o);
    chk("R3 first split offset", o, 924);
    op_cmp("R3 top split b", 1, 200, o);
    chk("R3 second split offset", o, 724);
    op_cmp("R3 top split c", 1, 100, o);
    op_cmp("R6 free isolated", 2, 724, o);
    op_cmp("R2 best fit picks 200 hole", 1, 150, o);
    chk("R2 best fit offset", o, 774);
  endtask

  task automatic t_tie();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    for (int k = 0; k < 4; k++) op_cmp("R3 fill", 1, 100, o);
    op_cmp("R6 free 924", 2, 924, o);
    op_cmp("R6 free 724", 2, 724, o);
    op_cmp("R2 tie exact", 1, 100, o);
    chk("R2 tie takes lowest address", o, 724);
  endtask

  task automatic t_nomem();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    op_cmp("R4 too large", 1, 2000, o);
    op_cmp("R4 zero length", 1, 0, o);
    op_cmp("R4 table unchanged", 1, AREA, o);
    chk("R4 area intact", o, 0);
  endtask

  task automatic t_full();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    for (int k = 0; k < DEPTH - 1; k++) op_cmp("R5 fill table", 1, 10, o);
    chk("R5 last fill offset", o, 974);
    op_cmp("R5 split refused when full", 1, 10, o);
    chk("R5 refused offset all ones", o, BAD);
    op_cmp("R5 open exact hole", 2, 994, o);
    op_cmp("R5 exact fit while full", 1, 10, o);
    chk("R5 exact fit offset", o, 994);
  endtask

  task automatic t_free_err();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    op_cmp("R3 alloc", 1, 100, o);
    op_cmp("R3 alloc", 1, 100, o);
    op_cmp("R6 free top", 2, 924, o);
    op_cmp("R6 double free", 2, 924, o);
    op_cmp("R6 free of free range", 2, 0, o);
    op_cmp("R6 free unknown offset", 2, 123, o);
    op_cmp("R6 nothing changed", 1, 100, o);
    chk("R6 hole still exact", o, 924);
  endtask

  task automatic t_merge();
    int o;
    op_cmp("R1 clear op", 0, 0, o);
    for (int k = 0; k < 4; k++) op_cmp("R7 fill", 1, 100, o);
    op_cmp("R7 free no neighbour", 2, 824, o);
    op_cmp("R7 free lower neighbour", 2, 924, o);
    op_cmp("R7 free upper neighbour", 2, 724, o);
    op_cmp("R7 merged upper span", 1, 300, o);
    chk("R7 upper merge span offset", o, 724);
    op_cmp("R7 give back", 2, 724, o);
    op_cmp("R7 free both neighbours", 2, 624, o);
    op_cmp("R7 full area after merges", 1, AREA, o);
    chk("R7 three-way merge offset", o, 0);
    op_cmp("R7 release", 2, 0, o);
  endtask

  task automatic t_handshake();
    int o, held;
    op_cmp("R1 clear op", 0, 0, o);
    op_cmp("R9 reserved op", 3, 5, o);
    op_cmp("R9 reserved left table", 1, AREA, o);
    op_cmp("R9 release", 2, 0, o);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_op = 2'd1;
    req_arg = AW'(100);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", int'(busy), 1);
    chk("R8 not ready while busy", int'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    held = int'(rsp_offset);
    chk("R8 held response offset", held, 924);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 response held valid", int'(rsp_valid), 1);
      chk("R8 response held stable", int'(rsp_offset), held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 response consumed", int'(rsp_valid), 0);
    chk("R8 idle after consume", int'(busy), 0);
    begin
      int e_o, e_s;
      m_alloc(100, e_o, e_s);
    end
  endtask

  task automatic t_mixed();
    int o, pick, cand;
    op_cmp("R1 clear op", 0, 0, o);
    for (int n = 0; n < 300; n++) begin
      pick = $urandom_range(0, 99);
      if (pick < 55) begin
        op_cmp("R2 mixed alloc", 1, $urandom_range(1, 300), o);
      end else if (pick < 95) begin
        cand = -1;
        for (int i = 0; i < m_cnt; i++)
          if (m_used[i] && (cand < 0 || $urandom_range(0, 1) == 1)) cand = m_off[i];
        if (cand < 0) cand = 0;
        op_cmp("R7 mixed free", 2, cand, o);
      end else begin
        op_cmp("R6 mixed bogus free", 2, $urandom_range(0, AREA - 1), o);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_best_fit();
    t_tie();
    t_nomem();
    t_full();
    t_free_err();
    t_merge();
    t_handshake();
    t_mixed();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule